// File: doc/BRIEF.md
# Delay-Line TDC Dual-Capture Compensator

This block turns snapshots of a tapped delay line into compensated arrival times. Once per sampling clock it receives the registered state of every tap. A hit edge travels along the line, so each snapshot is a thermometer pattern: the taps the edge has already passed read 1, and the rest read 0. The block corrects a lone flipped interior tap, then encodes the edge position as a code.

The line is longer than one clock period, so one hit is usually seen in two consecutive snapshots. The first code is N1 and the second is N2. Their difference D = N2 − N1 is the number of cells that span one clock period. It therefore gives a live measure of the cell delay, which drifts with temperature and supply.

The corrected time divides N1 by D. That division is replaced by the first-order series t = N1·TAP_T·(2·D0 − D)/D0, where D0 is a power of two, so the arithmetic needs only a multiply and a shift. When a measured D falls outside its legal window, the last accepted value is used instead. When no second capture follows, the raw scaled N1 is reported, with the calibrated flag cleared.

Top module: `tdc_dual_capture`

## Requirements
- R1: While reset is held, and after it, valid_o stays low until a hit has been resolved.
- R2: Tap 0 is the first cell the edge reaches. A snapshot carries an edge only when tap 0 reads 1 and tap TAPS−1 reads 0. Its code is the index of the first 0 after the leading run of 1s, so it lies in 1..TAPS−1. All-zero and all-one snapshots carry no edge.
- R3: An interior tap whose value differs from both of its neighbours is inverted before encoding.
- R4: Two snapshots may arrive on consecutive clocks, the second with a larger code. They form a pair: n1_o holds the first code, n2_o holds the second, and calib_o is 1. If the second snapshot is sampled at clock edge k, valid_o is high for exactly one cycle, after edge k+3.
- R5: For a pair, time_o = floor(N1·TAP_T·(2·D0 − D)/D0), where D = N2 − N1 (defaults: TAP_T=64, D0=32).
- R6: A D outside the inclusive window [D_MIN, D_MAX] (defaults 20..44) is not used. The last accepted D is used in its place, or D0 if none has been accepted since reset. calib_o stays 1, and only in-window values update the stored D.
- R7: The snapshot after an edge may carry no edge, or an edge whose code is not larger. The result is then reported alone, three clocks after that snapshot: n2_o = 0, calib_o = 0, time_o = N1·TAP_T. If that snapshot carries an edge, it starts a new hit, whose result may follow on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| taps_i | input | TAPS (48) | Registered delay-line tap states, tap 0 first |
| valid_o | output | 1 | One-cycle strobe marking a resolved hit |
| n1_o | output | CW (6) | Code of the first capture |
| n2_o | output | CW (6) | Code of the second capture, 0 if none |
| time_o | output | TW (16) | Corrected time, in units of 1/TAP_T of a nominal cell |
| calib_o | output | 1 | 1 when the time used a D-based correction |

## Verification
On every cycle, the checker confirms the following for each strobe. Reported codes lie in the legal range. A paired result has N2 above N1, and a lone result has N2 of zero. An uncorrected time equals the scaled N1. A corrected time lies between the values the window's two extreme D would give. Only the bench's scenarios can pin down the exact three-cycle latency, the bubble correction, and the reuse of a stored D after a rejected one. The same holds for back-to-back results when one capture gives way to a new hit, because each of these depends on a history of snapshots.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;

  // majority of three neighbouring taps; removes a lone flipped cell
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tdc_therm_encoder.sv
module tdc_therm_encoder #(
  parameter int TAPS = 48,
  parameter int CW   = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] taps_i,
  output logic            found_o,
  output logic [CW-1:0]   code_o
);

  logic [TAPS-1:0] snap_q;
  logic [TAPS-1:0] filt;
  logic [CW-1:0]   code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= taps_i;
  end

  assign filt[0]      = snap_q[0];
  assign filt[TAPS-1] = snap_q[TAPS-1];

  generate
    for (genvar g = 1; g < TAPS-1; g++) begin : g_flt
      assign filt[g] = tdc_pkg::maj3(snap_q[g-1], snap_q[g], snap_q[g+1]);
    end
  endgenerate

  // lowest 1->0 step wins
  always_comb begin
    code_d = '0;
    for (int i = TAPS-1; i >= 1; i--) begin
      if (!filt[i] && filt[i-1]) code_d = CW'(i);
    end
  end

  assign code_o  = code_d;
  assign found_o = filt[0] & ~filt[TAPS-1];

endmodule

// File: rtl/tdc_pair_tracker.sv
module tdc_pair_tracker #(
  parameter int CW      = 6,
  parameter int D0_LOG2 = 5,
  parameter int D_MIN   = 20,
  parameter int D_MAX   = 44,
  parameter int FW      = D0_LOG2 + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          found_i,
  input  logic [CW-1:0] code_i,
  output logic          vld_o,
  output logic [CW-1:0] n1_o,
  output logic [CW-1:0] n2_o,
  output logic [FW-1:0] fac_o,
  output logic          cal_o
);
  import tdc_pkg::*;

  localparam int D0 = 1 << D0_LOG2;

  trk_state_e    st_q, st_d;
  logic [CW-1:0] held_q, held_d;
  logic          held_en;
  logic [CW-1:0] dcal_q, dcal_d;
  logic          dcal_en;
  logic          emit;
  logic          vld_q;
  logic [CW-1:0] n1_q, n1_d, n2_q, n2_d;
  logic [FW-1:0] fac_q, fac_d;
  logic          cal_q, cal_d;
  logic [CW-1:0] diff, dsel;
  logic          in_win;

  assign diff   = code_i - held_q;
  assign in_win = (diff >= CW'(D_MIN)) && (diff <= CW'(D_MAX));
  assign dsel   = in_win ? diff : dcal_q;

  always_comb begin
    st_d    = st_q;
    held_d  = held_q;
    held_en = 1'b0;
    dcal_d  = dcal_q;
    dcal_en = 1'b0;
    emit    = 1'b0;
    n1_d    = held_q;
    n2_d    = '0;
    fac_d   = FW'(D0);
    cal_d   = 1'b0;
    case (st_q)
      TRK_IDLE: begin
        if (found_i) begin
          held_d  = code_i;
          held_en = 1'b1;
          st_d    = TRK_WAIT;
        end
      end
      TRK_WAIT: begin
        emit = 1'b1;
        if (found_i && (code_i > held_q)) begin
          n2_d  = code_i;
          fac_d = FW'(2 * D0) - FW'(dsel);
          cal_d = 1'b1;
          if (in_win) begin
            dcal_d  = diff;
            dcal_en = 1'b1;
          end
          st_d = TRK_IDLE;
        end else if (found_i) begin
          held_d  = code_i;
          held_en = 1'b1;
          st_d    = TRK_WAIT;
        end else begin
          st_d = TRK_IDLE;
        end
      end
      default: st_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_IDLE;
      held_q <= '0;
      dcal_q <= CW'(D0);
      vld_q  <= 1'b0;
      n1_q   <= '0;
      n2_q   <= '0;
      fac_q  <= '0;
      cal_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= emit;
      if (held_en) held_q <= held_d;
      if (dcal_en) dcal_q <= dcal_d;
      if (emit) begin
        n1_q  <= n1_d;
        n2_q  <= n2_d;
        fac_q <= fac_d;
        cal_q <= cal_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign n1_o  = n1_q;
  assign n2_o  = n2_q;
  assign fac_o = fac_q;
  assign cal_o = cal_q;

endmodule

// File: rtl/tdc_time_corrector.sv
module tdc_time_corrector #(
  parameter int CW      = 6,
  parameter int FW      = 7,
  parameter int TAP_T   = 64,
  parameter int TW      = 16,
  parameter int D0_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [CW-1:0] n1_i,
  input  logic [CW-1:0] n2_i,
  input  logic [FW-1:0] fac_i,
  input  logic          cal_i,
  output logic          vld_o,
  output logic [CW-1:0] n1_o,
  output logic [CW-1:0] n2_o,
  output logic [TW-1:0] time_o,
  output logic          cal_o
);

  localparam int BW = CW + $clog2(TAP_T) + 1;
  localparam int PW = BW + FW;

  // stage A: scale code to time units
  logic          a_vld_q;
  logic [CW-1:0] a_n1_q, a_n2_q;
  logic [FW-1:0] a_fac_q;
  logic          a_cal_q;
  logic [BW-1:0] a_base_q, a_base_d;

  // stage B: series correction and shift
  logic          b_vld_q;
  logic [CW-1:0] b_n1_q, b_n2_q;
  logic          b_cal_q;
  logic [TW-1:0] b_time_q, b_time_d;
  logic [PW-1:0] prod, shifted;

  assign a_base_d = BW'(n1_i) * BW'(TAP_T);
  assign prod     = PW'(a_base_q) * PW'(a_fac_q);
  assign shifted  = prod >> D0_LOG2;

  always_comb begin
    if (shifted > PW'({TW{1'b1}})) b_time_d = '1;
    else                           b_time_d = TW'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q  <= 1'b0;
      a_n1_q   <= '0;
      a_n2_q   <= '0;
      a_fac_q  <= '0;
      a_cal_q  <= 1'b0;
      a_base_q <= '0;
      b_vld_q  <= 1'b0;
      b_n1_q   <= '0;
      b_n2_q   <= '0;
      b_cal_q  <= 1'b0;
      b_time_q <= '0;
    end else begin
      a_vld_q <= vld_i;
      b_vld_q <= a_vld_q;
      if (vld_i) begin
        a_n1_q   <= n1_i;
        a_n2_q   <= n2_i;
        a_fac_q  <= fac_i;
        a_cal_q  <= cal_i;
        a_base_q <= a_base_d;
      end
      if (a_vld_q) begin
        b_n1_q   <= a_n1_q;
        b_n2_q   <= a_n2_q;
        b_cal_q  <= a_cal_q;
        b_time_q <= b_time_d;
      end
    end
  end

  assign vld_o  = b_vld_q;
  assign n1_o   = b_n1_q;
  assign n2_o   = b_n2_q;
  assign time_o = b_time_q;
  assign cal_o  = b_cal_q;

endmodule

// File: rtl/tdc_dual_capture.sv
module tdc_dual_capture #(
  parameter int TAPS    = 48,
  parameter int TAP_T   = 64,
  parameter int D0_LOG2 = 5,
  parameter int D_MIN   = 20,
  parameter int D_MAX   = 44,
  parameter int TW      = 16,
  parameter int CW      = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] taps_i,
  output logic            valid_o,
  output logic [CW-1:0]   n1_o,
  output logic [CW-1:0]   n2_o,
  output logic [TW-1:0]   time_o,
  output logic            calib_o
);

  localparam int FW = D0_LOG2 + 2;

  logic [1:0]    rsync_q;
  logic          rst_s;
  logic          found;
  logic [CW-1:0] code;
  logic          p_vld, p_cal;
  logic [CW-1:0] p_n1, p_n2;
  logic [FW-1:0] p_fac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  tdc_therm_encoder #(.TAPS(TAPS), .CW(CW)) u_enc (
    .clk     (clk),
    .rst_n   (rst_s),
    .taps_i  (taps_i),
    .found_o (found),
    .code_o  (code)
  );

  tdc_pair_tracker #(
    .CW(CW), .D0_LOG2(D0_LOG2), .D_MIN(D_MIN), .D_MAX(D_MAX), .FW(FW)
  ) u_trk (
    .clk     (clk),
    .rst_n   (rst_s),
    .found_i (found),
    .code_i  (code),
    .vld_o   (p_vld),
    .n1_o    (p_n1),
    .n2_o    (p_n2),
    .fac_o   (p_fac),
    .cal_o   (p_cal)
  );

  tdc_time_corrector #(
    .CW(CW), .FW(FW), .TAP_T(TAP_T), .TW(TW), .D0_LOG2(D0_LOG2)
  ) u_cor (
    .clk    (clk),
    .rst_n  (rst_s),
    .vld_i  (p_vld),
    .n1_i   (p_n1),
    .n2_i   (p_n2),
    .fac_i  (p_fac),
    .cal_i  (p_cal),
    .vld_o  (valid_o),
    .n1_o   (n1_o),
    .n2_o   (n2_o),
    .time_o (time_o),
    .cal_o  (calib_o)
  );

endmodule

// File: rtl/tdc_dual_capture_chk.sv
module tdc_dual_capture_chk #(
  parameter int TAPS    = 48,
  parameter int TAP_T   = 64,
  parameter int D0_LOG2 = 5,
  parameter int D_MIN   = 20,
  parameter int D_MAX   = 44,
  parameter int TW      = 16,
  parameter int CW      = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_o,
  input logic [CW-1:0] n1_o,
  input logic [CW-1:0] n2_o,
  input logic [TW-1:0] time_o,
  input logic          calib_o
);

  localparam int D0 = 1 << D0_LOG2;

  logic [31:0] scaled, lo_b, hi_b;

  always_comb begin
    scaled = 32'(n1_o) * 32'(TAP_T);
    lo_b   = (scaled * 32'(2 * D0 - D_MAX)) >> D0_LOG2;
    hi_b   = (scaled * 32'(2 * D0 - D_MIN)) >> D0_LOG2;
  end

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (n1_o >= CW'(1)) && (32'(n1_o) <= 32'(TAPS - 1)));

  assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && calib_o) |-> (n2_o > n1_o));

  assert_window_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && calib_o) |-> (32'(time_o) >= lo_b) && (32'(time_o) <= hi_b));

  assert_single_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !calib_o) |-> (n2_o == '0) && (32'(time_o) == scaled));

endmodule

bind tdc_dual_capture tdc_dual_capture_chk #(
  .TAPS(TAPS), .TAP_T(TAP_T), .D0_LOG2(D0_LOG2), .D_MIN(D_MIN),
  .D_MAX(D_MAX), .TW(TW), .CW(CW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_o (valid_o),
  .n1_o    (n1_o),
  .n2_o    (n2_o),
  .time_o  (time_o),
  .calib_o (calib_o)
);

// File: tb/tdc_dual_capture_tb.sv
module tdc_dual_capture_tb;

  localparam int TAPS = 48;
  localparam int CW   = 6;
  localparam int TW   = 16;

  logic            clk;
  logic            rst_n;
  logic [TAPS-1:0] taps_i;
  logic            valid_o;
  logic [CW-1:0]   n1_o, n2_o;
  logic [TW-1:0]   time_o;
  logic            calib_o;

  int errors = 0;
  int checks = 0;
  int dcal_m = 32;
  bit finished = 0;

  tdc_dual_capture u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .taps_i  (taps_i),
    .valid_o (valid_o),
    .n1_o    (n1_o),
    .n2_o    (n2_o),
    .time_o  (time_o),
    .calib_o (calib_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [TAPS-1:0] therm(input int n);
    logic [TAPS-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic int exp_time(input int n1, input int d);
    return (n1 * 64 * (64 - d)) / 32;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [TAPS-1:0] s);
    @(negedge clk);
    taps_i = s;
    @(posedge clk);
  endtask

  task automatic chk_out(input string req, input int n1, input int n2, input int t, input int cal);
    chk(req, "valid_o", int'(valid_o), 1);
    chk(req, "n1_o", int'(n1_o), n1);
    chk(req, "n2_o", int'(n2_o), n2);
    chk(req, "time_o", int'(time_o), t);
    chk(req, "calib_o", int'(calib_o), cal);
  endtask

  // model of stored calibration (R6)
  function automatic int pick_d(input int d);
    if (d >= 20 && d <= 44) begin
      dcal_m = d;
      return d;
    end
    return dcal_m;
  endfunction

  // A then B on consecutive edges; B sampled at edge k; strobe after k+3
  task automatic run_two(input string req, input logic [TAPS-1:0] a, input logic [TAPS-1:0] b,
                         input int n1, input int n2, input int t, input int cal);
    step(a);
    step(b);
    step('0);
    step('0);
    @(negedge clk);
    chk("R4", "valid_o early", int'(valid_o), 0);
    taps_i = '0;
    @(posedge clk);
    @(negedge clk);
    chk_out(req, n1, n2, t, cal);
    @(posedge clk);
    @(negedge clk);
    chk("R4", "valid_o pulse width", int'(valid_o), 0);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    taps_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid_o in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid_o after reset", int'(valid_o), 0);
  endtask

  task automatic t_pair_nominal();
    int d = pick_d(32);
    run_two("R5", therm(5), therm(37), 5, 37, exp_time(5, d), 1);
  endtask

  task automatic t_pair_slow();
    int d = pick_d(25);
    run_two("R5", therm(3), therm(28), 3, 28, exp_time(3, d), 1);
  endtask

  task automatic t_bubble_R3();
    logic [TAPS-1:0] a = therm(10);
    int d;
    a[4]  = 1'b0;
    a[20] = 1'b1;
    d = pick_d(36);
    run_two("R3", a, therm(46), 10, 46, exp_time(10, d), 1);
  endtask

  task automatic t_window_reject();
    int d;
    d = pick_d(45);
    run_two("R6", therm(2), therm(47), 2, 47, exp_time(2, d), 1);
    d = pick_d(10);
    run_two("R6", therm(4), therm(14), 4, 14, exp_time(4, d), 1);
  endtask

  task automatic t_window_edges();
    int d;
    d = pick_d(20);
    run_two("R6", therm(1), therm(21), 1, 21, exp_time(1, d), 1);
    d = pick_d(44);
    run_two("R6", therm(3), therm(47), 3, 47, exp_time(3, d), 1);
  endtask

  task automatic t_single();
    run_two("R7", therm(7), '0, 7, 0, 7 * 64, 0);
  endtask

  task automatic t_single_then_new_R7();
    int d;
    step(therm(30));
    step(therm(12));
    step(therm(40));
    step('0);
    @(negedge clk);
    chk("R4", "valid_o early", int'(valid_o), 0);
    taps_i = '0;
    @(posedge clk);
    @(negedge clk);
    chk_out("R7", 30, 0, 30 * 64, 0);
    d = pick_d(28);
    @(posedge clk);
    @(negedge clk);
    chk_out("R7", 12, 40, exp_time(12, d), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "valid_o after pair", int'(valid_o), 0);
  endtask

  task automatic t_no_edge_R2();
    int seen = 0;
    step('1);
    step('1);
    step(48'h0000_0000_00F0);
    step('0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      taps_i = '0;
      if (valid_o) seen++;
      @(posedge clk);
    end
    chk("R2", "strobes for edge-free snapshots", seen, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pair_nominal();
    t_pair_slow();
    t_bubble_R3();
    t_window_reject();
    t_window_edges();
    t_single();
    t_single_then_new_R7();
    t_no_edge_R2();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule